// File: doc/BRIEF.md
# Configurable GPIO and Alarm Mux

This block sits between eight general-purpose pads and the core of a four-port line interface. Each pad is set up by its own two-bit mode field. It can act as a plain input, a plain output driven from a data bit, a global timing signal, or an alarm output for the port that owns the pad. Pads are grouped in pairs, one pair to each port. The first pad of a pair can show that port's alarm A and the second pad its alarm B. A port that needs only one alarm can use its second pad for anything else.

Only the first pad of each port can carry a global signal, and each port has a fixed global role. On port 0 the pad is the 8 kHz reference input, on port 1 the timing-error input, and on port 2 the performance-monitor update input. On port 3 the pad drives the global reference output. The three core-side global inputs are held low unless their pad is in global mode. Each pad input is passed through a two-flop synchronizer before it is read back or routed into the core.

A port can be disabled with its enable flag. Its pads still work in every mode, but an output or alarm pad of that port drives a fixed low level.

Top module: `gpio_alarm_mux`

## Requirements
- R1: While reset is asserted, all pin output enables, pin drive values, readback bits and core global signals are 0.
- R2: Mode 00 (general input) deasserts the pin's output enable one clock edge after the mode is applied.
- R3: Mode 01 (general output) on a pin of an enabled port asserts the output enable and drives the pin's data bit, one edge after the inputs are applied.
- R4: Mode 01 on a pin of a disabled port asserts the output enable and drives 0, whatever the data bit holds.
- R5: Mode 11 (alarm) on an enabled port drives pin 2p with alarm A of port p and pin 2p+1 with alarm B of port p. A second pin set to another mode is unaffected by alarm B.
- R6: Mode 11 on a disabled port asserts the output enable and drives 0.
- R7: Mode 10 (global) on an odd-numbered pin, the second pin of its port, does not drive: the output enable is 0.
- R8: Mode 10 on pin 6 asserts the output enable and drives the global reference source input, whether or not port 3 is enabled.
- R9: Mode 10 on pin 0, 2 or 4 leaves the pin undriven and routes its synchronized input to core_ref8k, core_terr or core_pmu respectively.
- R10: Each core global signal is 0 while its designated pin (0, 2 or 4) is in any mode other than 10, even when that pin's input is high.
- R11: pin_rdbk bit i equals pin_in bit i as sampled two clock edges earlier, in every mode; after only one edge it still shows the older value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_mode | input | 16 | Two-bit mode per pin, pin i in bits [2i+1:2i] |
| pin_dout | input | 8 | Data driven by pins in general-output mode |
| alarm_a | input | 4 | Alarm A status per port |
| alarm_b | input | 4 | Alarm B status per port |
| glb_ref_src | input | 1 | Global reference driven on pin 6 in global mode |
| port_en | input | 4 | Per-port enable |
| pin_in | input | 8 | Values seen at the pads |
| pin_out | output | 8 | Pad drive values |
| pin_oe | output | 8 | Pad output enables |
| pin_rdbk | output | 8 | Synchronized pad input values |
| core_ref8k | output | 1 | 8 kHz reference into the core |
| core_terr | output | 1 | Timing-error input into the core |
| core_pmu | output | 1 | Performance-monitor update into the core |

## Verification
Pin drive values and output enables are registered. They take the new value one rising edge after a change of mode, data, alarm, enable or reference source. Readback and the core global signals pass through the two synchronizer flops, so a pad change appears at these outputs after the second rising edge. A mode change on a designated global pin gates the core signal within the same cycle. The bench changes inputs on the falling edge, waits the stated number of rising edges, and samples 2 ns later. For readback it also samples after one edge, to confirm that the older value is still held.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  typedef enum logic [1:0] {
    MD_IN  = 2'b00,
    MD_OUT = 2'b01,
    MD_GLB = 2'b10,
    MD_ALM = 2'b11
  } pin_mode_e;

  typedef enum logic [2:0] {
    GR_NONE,
    GR_REF_IN,
    GR_TERR_IN,
    GR_PMU_IN,
    GR_REF_OUT
  } glb_role_e;

  typedef struct packed {
    logic oe;
    logic dat;
  } drive_t;

  // Global role of a pin: only the first pin of each port carries one.
  function automatic glb_role_e role_of_pin(int unsigned pin);
    glb_role_e r;
    if ((pin % 2) != 0) begin
      r = GR_NONE;
    end else begin
      case ((pin / 2) % 4)
        0:       r = GR_REF_IN;
        1:       r = GR_TERR_IN;
        2:       r = GR_PMU_IN;
        default: r = GR_REF_OUT;
      endcase
    end
    return r;
  endfunction

  // Next drive state of one pad.
  function automatic drive_t pin_drive(pin_mode_e m, logic dout, logic alarm,
                                       logic en, logic gsrc, glb_role_e r);
    drive_t d;
    d = '0;
    case (m)
      MD_OUT: begin
        d.oe  = 1'b1;
        d.dat = en & dout;
      end
      MD_GLB: begin
        if (r == GR_REF_OUT) begin
          d.oe  = 1'b1;
          d.dat = gsrc;
        end
      end
      MD_ALM: begin
        d.oe  = 1'b1;
        d.dat = en & alarm;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

  // Count of edges since reset, saturating, for the latency check.
  logic [1:0] edges_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 edges_seen <= '0;
    else if (edges_seen != 2'd3) edges_seen <= edges_seen + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      // R11: readback is the pad value two edges back
      assert_rdbk_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_seen >= 2'd2) |-> (q == $past(d, 2)));
    end
  endgenerate

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_mux_pkg::*;
#(
  parameter int unsigned PIN_IDX = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       dout,
  input  logic       alarm,
  input  logic       en,
  input  logic       gsrc,
  output logic       pin_out,
  output logic       pin_oe
);

  localparam glb_role_e ROLE = role_of_pin(PIN_IDX);

  drive_t nxt_drive;
  drive_t cur_drive;
  logic   armed;

  assign nxt_drive = pin_drive(pin_mode_e'(mode), dout, alarm, en, gsrc, ROLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_drive <= '0;
      armed     <= 1'b0;
    end else begin
      cur_drive <= nxt_drive;
      armed     <= 1'b1;
    end
  end

  assign pin_out = cur_drive.dat;
  assign pin_oe  = cur_drive.oe;

  // R2: input mode releases the pad
  assert_input_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mode) == MD_IN) |-> !pin_oe);

  // R4 and R6: driving modes of a disabled port hold the pad low
  assert_disabled_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(en) && ($past(mode) == MD_OUT || $past(mode) == MD_ALM))
      |-> (pin_oe && !pin_out));

  // R5: alarm mode follows the port alarm
  assert_alarm_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(en) && $past(mode) == MD_ALM) |-> (pin_oe && pin_out == $past(alarm)));

  generate
    if (ROLE == GR_REF_OUT) begin : g_out_chk
      // R8: global mode drives the reference source
      assert_ref_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mode) == MD_GLB) |-> (pin_oe && pin_out == $past(gsrc)));
    end else begin : g_hiz_chk
      // R7 (second pins) and R9 (global input pins): global mode does not drive
      assert_glb_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mode) == MD_GLB) |-> !pin_oe);
    end
  endgenerate

endmodule

// File: rtl/gpio_glb_route.sv
module gpio_glb_route
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NUM_PINS-1:0] pin_mode,
  input  logic [NUM_PINS-1:0]   pin_sync,
  output logic                  core_ref8k,
  output logic                  core_terr,
  output logic                  core_pmu
);

  logic [NUM_PINS-1:0] glb_sel;
  logic [NUM_PINS-1:0] is_ref, is_terr, is_pmu;
  logic ref_sel, terr_sel, pmu_sel;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_sel
      localparam glb_role_e R = role_of_pin(gi);
      assign glb_sel[gi] = (pin_mode[2*gi +: 2] == MD_GLB);
      assign is_ref[gi]  = (R == GR_REF_IN)  && glb_sel[gi];
      assign is_terr[gi] = (R == GR_TERR_IN) && glb_sel[gi];
      assign is_pmu[gi]  = (R == GR_PMU_IN)  && glb_sel[gi];
    end
  endgenerate

  assign ref_sel  = |is_ref;
  assign terr_sel = |is_terr;
  assign pmu_sel  = |is_pmu;

  assign core_ref8k = |(is_ref  & pin_sync);
  assign core_terr  = |(is_terr & pin_sync);
  assign core_pmu   = |(is_pmu  & pin_sync);

  // R10: a core global stays low unless its pin is selected
  assert_ref_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_sel |-> !core_ref8k);
  assert_terr_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !terr_sel |-> !core_terr);
  assert_pmu_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pmu_sel |-> !core_pmu);

endmodule

// File: rtl/gpio_alarm_mux.sv
module gpio_alarm_mux
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4*NUM_PORTS-1:0]   pin_mode,
  input  logic [2*NUM_PORTS-1:0]   pin_dout,
  input  logic [NUM_PORTS-1:0]     alarm_a,
  input  logic [NUM_PORTS-1:0]     alarm_b,
  input  logic                     glb_ref_src,
  input  logic [NUM_PORTS-1:0]     port_en,
  input  logic [2*NUM_PORTS-1:0]   pin_in,
  output logic [2*NUM_PORTS-1:0]   pin_out,
  output logic [2*NUM_PORTS-1:0]   pin_oe,
  output logic [2*NUM_PORTS-1:0]   pin_rdbk,
  output logic                     core_ref8k,
  output logic                     core_terr,
  output logic                     core_pmu
);

  localparam int unsigned NUM_PINS = 2 * NUM_PORTS;

  logic [NUM_PINS-1:0] pin_sync;

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  assign pin_rdbk = pin_sync;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
      logic pin_alarm;
      if ((gi % 2) == 0) begin : g_first
        assign pin_alarm = alarm_a[gi/2];
      end else begin : g_second
        assign pin_alarm = alarm_b[gi/2];
      end

      gpio_pin_cell #(.PIN_IDX(gi)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (pin_mode[2*gi +: 2]),
        .dout    (pin_dout[gi]),
        .alarm   (pin_alarm),
        .en      (port_en[gi/2]),
        .gsrc    (glb_ref_src),
        .pin_out (pin_out[gi]),
        .pin_oe  (pin_oe[gi])
      );
    end
  endgenerate

  gpio_glb_route #(.NUM_PINS(NUM_PINS)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_mode   (pin_mode),
    .pin_sync   (pin_sync),
    .core_ref8k (core_ref8k),
    .core_terr  (core_terr),
    .core_pmu   (core_pmu)
  );

  // R1: nothing drives while reset is held
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (pin_oe == '0 && pin_out == '0 && pin_rdbk == '0);
    end
  end

endmodule

// File: tb/gpio_alarm_mux_tb.sv
`timescale 1ns/1ps
module gpio_alarm_mux_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_mode = '0;
  logic [7:0]  pin_dout = '0;
  logic [3:0]  alarm_a = '0, alarm_b = '0;
  logic        glb_ref_src = 1'b0;
  logic [3:0]  port_en = '0;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe, pin_rdbk;
  logic        core_ref8k, core_terr, core_pmu;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  gpio_alarm_mux u_dut (
    .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .pin_dout(pin_dout),
    .alarm_a(alarm_a), .alarm_b(alarm_b), .glb_ref_src(glb_ref_src),
    .port_en(port_en), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_rdbk(pin_rdbk), .core_ref8k(core_ref8k), .core_terr(core_terr),
    .core_pmu(core_pmu)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] all_modes(logic [1:0] m);
    return {8{m}};
  endfunction

  task automatic wait_edges(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    pin_in = 8'hFF; pin_mode = all_modes(2'b01); pin_dout = 8'hFF; port_en = 4'hF;
    wait_edges(3);
    chk("R1 oe in reset", pin_oe, 8'h00);
    chk("R1 out in reset", pin_out, 8'h00);
    chk("R1 rdbk in reset", pin_rdbk, 8'h00);
    chk("R1 core in reset", {core_ref8k, core_terr, core_pmu}, 3'b000);
    @(negedge clk);
    pin_in = '0; pin_mode = '0; pin_dout = '0;
    rst_n = 1'b1;
    wait_edges(1);
    chk("R2 oe after reset input mode", pin_oe, 8'h00);
  endtask

  task automatic t_general_out();
    @(negedge clk);
    port_en = 4'hF; pin_mode = all_modes(2'b01); pin_dout = 8'hA5;
    wait_edges(1);
    chk("R3 out A5", pin_out, 8'hA5);
    chk("R3 oe", pin_oe, 8'hFF);
    @(negedge clk);
    pin_dout = 8'h5A;
    wait_edges(1);
    chk("R3 out 5A", pin_out, 8'h5A);
    @(negedge clk);
    pin_mode = all_modes(2'b00);
    wait_edges(1);
    chk("R2 oe released", pin_oe, 8'h00);
  endtask

  task automatic t_disabled_out();
    @(negedge clk);
    port_en = 4'b1010; pin_mode = all_modes(2'b01); pin_dout = 8'hFF;
    wait_edges(1);
    chk("R4 out disabled ports low", pin_out, 8'hCC);
    chk("R4 oe", pin_oe, 8'hFF);
  endtask

  task automatic t_alarm();
    logic [7:0] exp;
    @(negedge clk);
    port_en = 4'hF; pin_mode = all_modes(2'b11); pin_dout = 8'h00;
    alarm_a = 4'b0101; alarm_b = 4'b0011;
    for (int p = 0; p < 4; p++) begin
      exp[2*p]   = alarm_a[p];
      exp[2*p+1] = alarm_b[p];
    end
    wait_edges(1);
    chk("R5 alarm pins", pin_out, exp);
    @(negedge clk);
    pin_mode[11:10] = 2'b01; pin_dout = 8'h20; alarm_b = 4'b0000;
    alarm_a = 4'b1111;
    wait_edges(1);
    chk("R5 second pin free", pin_out, 8'h75);
    @(negedge clk);
    pin_mode = all_modes(2'b11); port_en = 4'h0; alarm_a = 4'hF; alarm_b = 4'hF;
    wait_edges(1);
    chk("R6 disabled alarm out", pin_out, 8'h00);
    chk("R6 disabled alarm oe", pin_oe, 8'hFF);
  endtask

  task automatic t_global();
    @(negedge clk);
    port_en = 4'hF; pin_mode = all_modes(2'b10); glb_ref_src = 1'b1; pin_in = 8'h00;
    wait_edges(1);
    chk("R7 R9 only pin6 drives", pin_oe, 8'h40);
    chk("R8 pin6 follows src", pin_out, 8'h40);
    @(negedge clk);
    port_en = 4'h0; glb_ref_src = 1'b0;
    wait_edges(1);
    chk("R8 disabled port src low", pin_out, 8'h00);
    @(negedge clk);
    glb_ref_src = 1'b1;
    wait_edges(1);
    chk("R8 disabled port src high", {pin_oe[6], pin_out[6]}, 2'b11);
    @(negedge clk);
    pin_in = 8'h15;
    wait_edges(1);
    chk("R9 core not yet", {core_ref8k, core_terr, core_pmu}, 3'b000);
    wait_edges(1);
    chk("R9 core all", {core_ref8k, core_terr, core_pmu}, 3'b111);
    @(negedge clk);
    pin_in = 8'h04;
    wait_edges(2);
    chk("R9 core terr only", {core_ref8k, core_terr, core_pmu}, 3'b010);
  endtask

  task automatic t_gating();
    @(negedge clk);
    port_en = 4'hF; pin_mode = all_modes(2'b01); pin_in = 8'hFF;
    wait_edges(2);
    chk("R10 core low out mode", {core_ref8k, core_terr, core_pmu}, 3'b000);
    @(negedge clk);
    pin_mode = all_modes(2'b00);
    pin_mode[3:2] = 2'b10; pin_mode[7:6] = 2'b10; pin_mode[11:10] = 2'b10;
    pin_in = 8'h2A;
    wait_edges(2);
    chk("R10 second pins not sources", {core_ref8k, core_terr, core_pmu}, 3'b000);
    chk("R7 second pins undriven", pin_oe, 8'h00);
  endtask

  task automatic t_readback();
    @(negedge clk);
    pin_mode = all_modes(2'b11); pin_in = 8'h3C;
    wait_edges(2);
    @(negedge clk);
    pin_in = 8'hC3;
    wait_edges(1);
    chk("R11 old after one edge", pin_rdbk, 8'h3C);
    wait_edges(1);
    chk("R11 new after two edges", pin_rdbk, 8'hC3);
    @(negedge clk);
    pin_mode = all_modes(2'b01); pin_in = 8'h81;
    wait_edges(2);
    chk("R11 output mode readback", pin_rdbk, 8'h81);
  endtask

  initial begin
    t_reset();
    t_general_out();
    t_disabled_out();
    t_alarm();
    t_global();
    t_gating();
    t_readback();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule